// File: doc/BRIEF.md
# DDR2 SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory interface. It takes the device from reset to ready for normal traffic. After reset is released it holds the clock-enable low and the command bus idle for a long settling interval. It then raises clock-enable and walks through the fixed bring-up order: precharge-all, the four mode-register loads with DLL enable and DLL reset, a second precharge-all, a burst of auto-refreshes, the operating mode load, and the two output-driver calibration loads (default, then exit). Every command is followed by an exact number of idle cycles that suits its kind.

All waits are counted in controller clock cycles and set by parameters, and the mode-register contents are parameters too. The completion flag is gated by a separate countdown that starts at the DLL-reset command. Traffic therefore cannot begin before the DLL has had its lock time, even when the remaining steps finish sooner. The on-die termination control is held low for the whole run. The read/write datapath, periodic refresh and supply monitoring live elsewhere.

Top module: `ddr2_boot_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `ck_en`=0, command NOP, `ba`=0, `addr`=0 and `init_done`=0. Releasing reset restarts the whole sequence from the settling wait, including from the middle of a previous run.
- R2: After reset release, `ck_en` stays low for exactly `T_STABLE` cycles. It rises on the (`T_STABLE`+1)-th clock edge and never falls again until the next reset, and no non-NOP command is issued while it is low.
- R3: The first command is PRECHARGE-ALL, issued `T_CKE`+1 edges after `ck_en` rises. Every PRECHARGE-ALL drives `addr[10]`=1, with all other address bits and `ba` at 0.
- R4: The non-NOP commands appear in exactly this order, and nothing else is issued: PRE-ALL, LOAD(EMR2), LOAD(EMR3), LOAD(EMR DLL enable), LOAD(MR DLL reset), PRE-ALL, `N_REF` × REFRESH, LOAD(MR operating), LOAD(EMR OCD default), LOAD(EMR OCD exit).
- R5: The EMR2 load uses `ba`=2 with `addr[7]`=`SR_RATE` and all other bits 0. The EMR3 load uses `ba`=3 with `addr` all 0.
- R6: The DLL-enable load uses `ba`=1 and `addr`=0, which leaves A0 (DLL disable) at 0. The DLL-reset load uses `ba`=0 with only `addr[8]` set. The DLL-reset command is issued once per sequence.
- R7: Exactly `N_REF` REFRESH commands are issued, each with `ba`=0 and `addr`=0.
- R8: The operating mode load uses `ba`=0 and `addr`=`MR_OPER` with bit 8 forced to 0.
- R9: The OCD-default load uses `ba`=1 and `addr`=`EMR_OPER` with bits 9:7 forced to 1 and bit 0 forced to 0. The OCD-exit load uses the same value with bits 9:7 forced to 0.
- R10: Between a command and the next one there are exactly `T_MRD` NOP cycles after a LOAD, `T_RP` after a PRECHARGE and `T_RFC` after a REFRESH. The delay values must be at least 1.
- R11: `init_done` rises on edge max(M+`T_DLL`+1, X+`T_MRD`+1), where M is the edge that issued the DLL reset and X the edge that issued the OCD exit. Once high, it stays high until reset.
- R12: The command pins (`cs_n`,`ras_n`,`cas_n`,`we_n`) are 0111 for NOP, 0000 for LOAD MODE, 0010 for PRECHARGE and 0001 for REFRESH. `odt` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| ck_en | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address; selects the mode register on loads |
| addr | output | ADDR_W | Address bus; carries mode-register contents |
| odt | output | 1 | On-die termination control, held low |
| init_done | output | 1 | Device may accept normal traffic |

## Verification
The embedded properties check these rules on every cycle: reset quiets the bus, clock-enable never drops once raised, no command is issued with clock-enable low, each command is followed by at least one NOP, every precharge carries A10, and the DLL reset happens only once per run. A port-side counter from the observed DLL-reset command proves that the done flag never rises before the lock interval has elapsed. Only the bench scenarios can show the full command order, the exact bit pattern of each mode load, the exact idle gap after each command kind, the exact edge on which done rises, and a clean restart when reset hits the middle of the sequence.

// File: rtl/ddr2_boot_pkg.sv
package ddr2_boot_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_LMR,
        CMD_PRE,
        CMD_REF
    } ddr_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    typedef enum logic [3:0] {
        ST_CKE,
        ST_PRE1,
        ST_EMR2,
        ST_EMR3,
        ST_EMR1,
        ST_MRRST,
        ST_PRE2,
        ST_REF,
        ST_MROP,
        ST_OCDD,
        ST_OCDX,
        ST_FIN,
        ST_DONE
    } step_e;

    // Address bit positions decoded by the device
    localparam int unsigned BIT_ALLBANK = 10;
    localparam int unsigned BIT_DLLRST  = 8;
    localparam int unsigned BIT_SRATE   = 7;
    localparam int unsigned BIT_OCD_LO  = 7;
    localparam int unsigned BIT_OCD_HI  = 9;
    localparam int unsigned BIT_DLLOFF  = 0;

    function automatic cmd_pins_t encode_cmd(ddr_cmd_e c);
        cmd_pins_t p;
        case (c)
            CMD_LMR: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2_boot_timer.sv
module ddr2_boot_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R10: a new wait is only started once the previous one has run out
    p_load_after_expiry_r10: assert property (@(posedge clk) disable iff (rst)
        load |-> expired);

endmodule

// File: rtl/ddr2_boot_dll_wait.sv
module ddr2_boot_dll_wait #(
    parameter int unsigned T_DLL = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic ready
);
    localparam int unsigned DW = $clog2(T_DLL + 1);

    logic          armed_q;
    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            armed_q <= 1'b1;
            cnt_q   <= DW'(T_DLL);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign ready = armed_q && (cnt_q == '0);

    // R6: the DLL reset is requested only once per sequence
    p_single_dll_reset_r6: assert property (@(posedge clk) disable iff (rst)
        start |-> !armed_q);

endmodule

// File: rtl/ddr2_boot_seq.sv
module ddr2_boot_seq
    import ddr2_boot_pkg::*;
#(
    parameter int unsigned T_STABLE = 50000,
    parameter int unsigned T_CKE    = 100,
    parameter int unsigned T_MRD    = 2,
    parameter int unsigned T_RP     = 4,
    parameter int unsigned T_RFC    = 32,
    parameter int unsigned N_REF    = 2,
    parameter int unsigned T_DLL    = 200,
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned BA_W     = 3,
    parameter logic [ADDR_W-1:0] MR_OPER  = ADDR_W'(14'h0432),
    parameter logic [ADDR_W-1:0] EMR_OPER = ADDR_W'(14'h0044),
    parameter logic              SR_RATE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              ck_en,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              odt,
    output logic              init_done
);
    localparam int unsigned MAXD  = max_u(max_u(T_STABLE, T_CKE),
                                          max_u(max_u(T_MRD, T_RP), T_RFC));
    localparam int unsigned CNT_W = $clog2(MAXD + 1);
    localparam int unsigned REF_W = $clog2(N_REF + 1);
    localparam int unsigned SW    = $clog2(T_DLL + 2);

    step_e               step_q, nxt_step;
    logic [REF_W-1:0]    ref_left_q;
    cmd_pins_t           pins_q;
    logic [BA_W-1:0]     ba_q, nxt_ba;
    logic [ADDR_W-1:0]   addr_q, nxt_addr;
    logic                cke_q, done_q;
    ddr_cmd_e            nxt_cmd;
    logic [CNT_W-1:0]    nxt_delay;
    logic                cke_rise, tmr_expired, dll_ready, fire, dll_start;

    ddr2_boot_timer #(
        .W       (CNT_W),
        .RST_VAL (T_STABLE)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (fire),
        .load_val (nxt_delay),
        .expired  (tmr_expired)
    );

    ddr2_boot_dll_wait #(
        .T_DLL (T_DLL)
    ) u_dll (
        .clk   (clk),
        .rst   (rst),
        .start (dll_start),
        .ready (dll_ready)
    );

    // Action taken when the current step's wait has run out
    always_comb begin
        nxt_cmd   = CMD_NOP;
        nxt_ba    = '0;
        nxt_addr  = '0;
        nxt_delay = '0;
        nxt_step  = step_q;
        cke_rise  = 1'b0;
        case (step_q)
            ST_CKE: begin
                cke_rise  = 1'b1;
                nxt_delay = CNT_W'(T_CKE);
                nxt_step  = ST_PRE1;
            end
            ST_PRE1, ST_PRE2: begin
                nxt_cmd               = CMD_PRE;
                nxt_addr[BIT_ALLBANK] = 1'b1;
                nxt_delay             = CNT_W'(T_RP);
                nxt_step              = (step_q == ST_PRE1) ? ST_EMR2 : ST_REF;
            end
            ST_EMR2: begin
                nxt_cmd             = CMD_LMR;
                nxt_ba              = BA_W'(2);
                nxt_addr[BIT_SRATE] = SR_RATE;
                nxt_delay           = CNT_W'(T_MRD);
                nxt_step            = ST_EMR3;
            end
            ST_EMR3: begin
                nxt_cmd   = CMD_LMR;
                nxt_ba    = BA_W'(3);
                nxt_delay = CNT_W'(T_MRD);
                nxt_step  = ST_EMR1;
            end
            ST_EMR1: begin
                nxt_cmd   = CMD_LMR;
                nxt_ba    = BA_W'(1);
                nxt_delay = CNT_W'(T_MRD);
                nxt_step  = ST_MRRST;
            end
            ST_MRRST: begin
                nxt_cmd              = CMD_LMR;
                nxt_addr[BIT_DLLRST] = 1'b1;
                nxt_delay            = CNT_W'(T_MRD);
                nxt_step             = ST_PRE2;
            end
            ST_REF: begin
                nxt_cmd   = CMD_REF;
                nxt_delay = CNT_W'(T_RFC);
                nxt_step  = (ref_left_q == REF_W'(1)) ? ST_MROP : ST_REF;
            end
            ST_MROP: begin
                nxt_cmd              = CMD_LMR;
                nxt_addr             = MR_OPER;
                nxt_addr[BIT_DLLRST] = 1'b0;
                nxt_delay            = CNT_W'(T_MRD);
                nxt_step             = ST_OCDD;
            end
            ST_OCDD, ST_OCDX: begin
                nxt_cmd                          = CMD_LMR;
                nxt_ba                           = BA_W'(1);
                nxt_addr                         = EMR_OPER;
                nxt_addr[BIT_DLLOFF]             = 1'b0;
                nxt_addr[BIT_OCD_HI:BIT_OCD_LO]  = (step_q == ST_OCDD) ? 3'b111 : 3'b000;
                nxt_delay                        = CNT_W'(T_MRD);
                nxt_step                         = (step_q == ST_OCDD) ? ST_OCDX : ST_FIN;
            end
            ST_FIN:  nxt_step = ST_DONE;
            default: ;
        endcase
    end

    assign fire      = tmr_expired && (step_q != ST_DONE) &&
                       ((step_q != ST_FIN) || dll_ready);
    assign dll_start = fire && (step_q == ST_MRRST);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q     <= ST_CKE;
            ref_left_q <= REF_W'(N_REF);
            pins_q     <= encode_cmd(CMD_NOP);
            ba_q       <= '0;
            addr_q     <= '0;
            cke_q      <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            pins_q <= encode_cmd(fire ? nxt_cmd : CMD_NOP);
            ba_q   <= fire ? nxt_ba : '0;
            addr_q <= fire ? nxt_addr : '0;
            if (fire) begin
                step_q <= nxt_step;
                if (cke_rise)
                    cke_q <= 1'b1;
                if (step_q == ST_REF)
                    ref_left_q <= ref_left_q - 1'b1;
                if (step_q == ST_FIN)
                    done_q <= 1'b1;
            end
        end
    end

    assign ck_en     = cke_q;
    assign cs_n      = pins_q.cs_n;
    assign ras_n     = pins_q.ras_n;
    assign cas_n     = pins_q.cas_n;
    assign we_n      = pins_q.we_n;
    assign ba        = ba_q;
    assign addr      = addr_q;
    assign odt       = 1'b0;
    assign init_done = done_q;

    // ---------------- assertions on the port behaviour ----------------
    logic          mr_rst_seen;
    logic          seen_q;
    logic [SW-1:0] since_q;
    logic          bus_idle;

    assign bus_idle    = ras_n && cas_n && we_n;
    assign mr_rst_seen = !cs_n && !ras_n && !cas_n && !we_n &&
                         (ba == '0) && addr[BIT_DLLRST];

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 1'b0;
            since_q <= '0;
        end else if (mr_rst_seen) begin
            seen_q  <= 1'b1;
            since_q <= SW'(1);
        end else if (seen_q && since_q != SW'(T_DLL + 1)) begin
            since_q <= since_q + 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!ck_en && !init_done && !cs_n && bus_idle && ba == '0 && addr == '0));

    p_cke_hold_r2: assert property (@(posedge clk) disable iff (rst)
        ck_en |=> ck_en);

    p_cmd_needs_cke_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_idle |-> ck_en);

    p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && cas_n && !we_n) |-> addr[BIT_ALLBANK]);

    p_nop_after_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_idle |=> bus_idle);

    p_done_after_lock_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (seen_q && since_q > SW'(T_DLL)));

    p_done_hold_r11: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

endmodule

// File: tb/ddr2_boot_seq_tb_top.sv
module ddr2_boot_seq_tb_top;

    localparam int unsigned TB_STABLE = 30;
    localparam int unsigned TB_CKE    = 8;
    localparam int unsigned TB_MRD    = 2;
    localparam int unsigned TB_RP     = 3;
    localparam int unsigned TB_RFC    = 7;
    localparam int unsigned TB_NREF   = 3;
    localparam int unsigned TB_DLL    = 200;
    localparam int unsigned TB_AW     = 14;
    localparam int unsigned TB_BW     = 3;
    localparam logic [13:0] TB_MR     = 14'h0963;
    localparam logic [13:0] TB_EMR    = 14'h0245;
    localparam logic        TB_SR     = 1'b1;

    // Pin codes {cs_n, ras_n, cas_n, we_n}, see R12
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_LM  = 4'b0000;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_REF = 4'b0001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic             ck_en, cs_n, ras_n, cas_n, we_n, odt, init_done;
    logic [TB_BW-1:0] ba;
    logic [TB_AW-1:0] addr;

    ddr2_boot_seq #(
        .T_STABLE (TB_STABLE),
        .T_CKE    (TB_CKE),
        .T_MRD    (TB_MRD),
        .T_RP     (TB_RP),
        .T_RFC    (TB_RFC),
        .N_REF    (TB_NREF),
        .T_DLL    (TB_DLL),
        .ADDR_W   (TB_AW),
        .BA_W     (TB_BW),
        .MR_OPER  (TB_MR),
        .EMR_OPER (TB_EMR),
        .SR_RATE  (TB_SR)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .ck_en     (ck_en),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .odt       (odt),
        .init_done (init_done)
    );

    typedef struct {
        logic [3:0]       pins;
        logic [TB_BW-1:0] bank;
        logic [TB_AW-1:0] a;
        int               at;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   exp_done_at;
    int   push_t;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    logic in_rst = 1'b1;

    always @(posedge clk) begin
        in_rst <= rst;
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s at cyc %0d actual=%0h expected=%0h", tag, what, cyc, act, expv);
        end
    endtask

    task automatic add(logic [3:0] p, int b, logic [TB_AW-1:0] a, string tag, int unsigned gap);
        exp_t e;
        e.pins = p;
        e.bank = TB_BW'(b);
        e.a    = a;
        e.at   = push_t;
        e.tag  = tag;
        exp_q.push_back(e);
        push_t = push_t + int'(gap) + 1;
    endtask

    // Driver: builds the expected command stream from the requirements
    task automatic push_sequence();
        int mr_at, ox_at;
        logic [TB_AW-1:0] a10, a8;
        a10 = '0; a10[10] = 1'b1;
        a8  = '0; a8[8]   = 1'b1;
        exp_q.delete();
        push_t = int'(TB_STABLE) + 1 + int'(TB_CKE) + 1;                    // R3
        add(P_PRE, 0, a10, "R3", TB_RP);
        add(P_LM, 2, TB_AW'(TB_SR) << 7, "R5", TB_MRD);
        add(P_LM, 3, '0, "R5", TB_MRD);
        add(P_LM, 1, '0, "R6", TB_MRD);
        mr_at = push_t;
        add(P_LM, 0, a8, "R6", TB_MRD);
        add(P_PRE, 0, a10, "R3", TB_RP);
        for (int i = 0; i < int'(TB_NREF); i++)
            add(P_REF, 0, '0, "R7", TB_RFC);
        add(P_LM, 0, TB_MR & ~14'h0100, "R8", TB_MRD);
        add(P_LM, 1, (TB_EMR | 14'h0380) & ~14'h0001, "R9", TB_MRD);
        ox_at = push_t;
        add(P_LM, 1, TB_EMR & ~14'h0381, "R9", TB_MRD);
        exp_done_at = mr_at + int'(TB_DLL) + 1;                              // R11
        if (ox_at + int'(TB_MRD) + 1 > exp_done_at)
            exp_done_at = ox_at + int'(TB_MRD) + 1;
    endtask

    // Monitor: compares the observed bus against the scoreboard queue
    always @(negedge clk) begin
        logic [3:0] pins;
        exp_t       e;
        pins = {cs_n, ras_n, cas_n, we_n};
        if (in_rst) begin
            check(!ck_en && !init_done && pins == P_NOP && ba == '0 && addr == '0,
                  "R1", "reset outputs {cke,done,pins}", {ck_en, init_done, pins}, {2'b00, P_NOP});
        end else begin
            check(odt == 1'b0, "R12", "odt", odt, 0);
            check(ck_en == (cyc >= int'(TB_STABLE) + 1), "R2", "ck_en", ck_en, cyc >= int'(TB_STABLE) + 1);
            check(init_done == (cyc >= exp_done_at), "R11", "init_done", init_done, cyc >= exp_done_at);
            if (pins != P_NOP) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected command pins", pins, P_NOP);
                end else begin
                    e = exp_q.pop_front();
                    check(pins == e.pins, "R4", "command pins (R12 codes)", pins, e.pins);
                    check(ba == e.bank, e.tag, "bank", ba, e.bank);
                    check(addr == e.a, e.tag, "address", addr, e.a);
                    check(cyc == e.at, "R10", "issue cycle", cyc, e.at);
                end
            end
        end
    end

    task automatic do_reset(int n);
        @(negedge clk);
        rst = 1'b1;
        repeat (n) @(negedge clk);
        push_sequence();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_done(string label);
        int guard;
        guard = 0;
        while (!init_done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R4", {label, ": commands left unissued"}, exp_q.size(), 0);
        check(init_done == 1'b1, "R11", {label, ": done held"}, init_done, 1);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        push_sequence();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        run_to_done("first run");

        // Full reset after completion, second clean run
        do_reset(3);
        run_to_done("second run");

        // Reset in the middle of the sequence, then restart (R1)
        do_reset(2);
        while (cyc < int'(TB_STABLE + TB_CKE) + 25) @(negedge clk);
        do_reset(2);
        run_to_done("restart run");

        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        report();
        $finish;
    end

endmodule